// File: doc/BRIEF.md
# Ring Descriptor Copy Engine

This block is the execution engine behind one copy channel. Software fills a submission ring in memory with fixed 32-byte work entries and moves a tail doorbell forward. The engine then takes the entries one at a time, starting at its own head index. For each entry it reads all eight words, checks the opcode and the byte count, and copies the payload one 32-bit word at a time. It then writes a 16-byte completion record into the partner completion ring.

Both rings have the same depth. Each entry produces exactly one completion record, so one index serves as the submission head and as the completion write slot. Once the last completion word has been accepted, the index steps forward with wrap-around. If the entry asked for a completion interrupt, a one-cycle request follows. The memory side is a single word-wide request/ready port. Reads return one beat later, marked by a valid strobe.

Top module: `ring_copy_engine`

## Requirements
- R1: While reset is low at a clock edge, and in the first cycle after it, `sq_head` is 0, `irq` is 0 and `mem_req` is 0.
- R2: No memory request is issued while `enable` is low or while `sq_head` equals `sq_tail`. An entry already in progress still runs to completion.
- R3: Each entry begins with eight word reads at `sq_base + head*32 + 4*k`, for k = 0 to 7 in ascending order. Word 0 holds the opcode in bits 3:0 and the interrupt request in bit 8. Word 3 is the byte length. Words 5:4 are the 64-bit source address and words 7:6 are the 64-bit destination address.
- R4: With opcode 0x4 and a nonzero length that is a multiple of 4, the engine moves length/4 words. For each offset in ascending order it reads `src+off` and then writes that data to `dst+off`. The word after the end of the destination is not written.
- R5: Any opcode other than 0x4 completes with status 1 and touches neither source nor destination. This includes 0x1. Opcode errors take precedence over length errors.
- R6: Opcode 0x4 with a length of 0 completes with status 2 and makes no data access.
- R7: Opcode 0x4 with a length that is not a multiple of 4 completes with status 3 and makes no data access.
- R8: After the last data write, the completion record is written as four words at `cq_base + head*16 + 4*k`, in ascending order. Words 0 and 1 are 0. Word 2 carries the advanced head index in bits 15:0. Word 3 has the valid flag in bit 16 and the status in bits 31:17, where 0 means success.
- R9: `sq_head` changes only when the last completion word is accepted. It advances by one, and after `depth_m1` it wraps to 0.
- R10: `irq` is high for exactly the one cycle after the last completion word is accepted, and only when bit 8 of word 0 is set.
- R11: A request that is not accepted holds `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` unchanged until `mem_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Allows new entries to be started |
| sq_base | input | ADDR_W | Byte address of submission ring slot 0 |
| cq_base | input | ADDR_W | Byte address of completion ring slot 0 |
| depth_m1 | input | IDX_W | Ring depth minus one (last valid index) |
| sq_tail | input | IDX_W | Doorbell: index one past the last posted entry |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_ready | input | 1 | Request accepted this cycle |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| sq_head | output | IDX_W | Index of the next entry to consume |
| irq | output | 1 | One-cycle completion interrupt request |

## Verification
The bench sweeps every payload length from one word to twelve words under four memory-ready patterns, and replays every access against a sequence computed from the entry. An engine with an off-by-one loop end would show up as a missing or extra data access, or as a clobbered sentinel after the destination. Error entries check the ordering of the status codes: an illegal opcode combined with a zero length must report the opcode error, and a wrong priority would report status 2 instead. The head is driven across the ring end, both within one batch and between batches. Errors in wrap handling appear as wrong completion slots and wrong head values in word 2. A stalled ready that changed the address, or an interrupt that was late or repeated, would break the hold and pulse checks.

// File: rtl/ring_pkg.sv
// Shared definitions for the ring copy engine.
// Assumes 32-bit memory words and the fixed entry layout described in the brief.
package ring_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH_REQ,
        ST_FETCH_WAIT,
        ST_DECODE,
        ST_RD_REQ,
        ST_RD_WAIT,
        ST_WR_REQ,
        ST_CPL_REQ
    } eng_state_e;

    localparam int unsigned SQE_WORDS = 8;
    localparam int unsigned CQE_WORDS = 4;

    localparam logic [3:0] OP_COPY = 4'h4;

    localparam logic [14:0] CST_OK        = 15'd0;
    localparam logic [14:0] CST_BAD_OP    = 15'd1;
    localparam logic [14:0] CST_ZERO_LEN  = 15'd2;
    localparam logic [14:0] CST_UNALIGNED = 15'd3;

endpackage

// File: rtl/ring_index.sv
// Wrap-around ring index shared by the submission head and the completion slot.
// Assumes depth_m1 stays constant while the engine is busy.
module ring_index #(
    parameter int unsigned IDX_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    input  logic [IDX_W-1:0] last,
    output logic [IDX_W-1:0] idx,
    output logic [IDX_W-1:0] nxt
);

    // next index, wrapping after the last valid slot
    always_comb begin
        nxt = (idx == last) ? '0 : idx + 1'b1;
    end

    // index register, moves only on an advance pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx <= '0;
        end else if (adv) begin
            idx <= nxt;
        end
    end

    // any change is a step of one or a wrap to zero
    assert_index_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (idx != $past(idx)) |-> (idx == '0 || idx == $past(idx) + 1'b1));

endmodule

// File: rtl/sqe_decode.sv
// Classifies a fetched submission entry: whether data is moved, the
// completion status and the interrupt request. Purely combinational.
// Assumes opcode errors rank above zero length, which ranks above misalignment.
module sqe_decode
    import ring_pkg::*;
(
    input  logic [3:0]  opcode,
    input  logic        irq_bit,
    input  logic [31:0] byte_len,
    output logic        do_copy,
    output logic [14:0] status,
    output logic        want_irq
);

    // ranked status selection
    always_comb begin
        if (opcode != OP_COPY) begin
            status = CST_BAD_OP;
        end else if (byte_len == 32'd0) begin
            status = CST_ZERO_LEN;
        end else if (byte_len[1:0] != 2'b00) begin
            status = CST_UNALIGNED;
        end else begin
            status = CST_OK;
        end
        do_copy  = (status == CST_OK);
        want_irq = irq_bit;
    end

endmodule

// File: rtl/ring_copy_engine.sv
// One-channel ring descriptor processor. Fetches 32-byte submission entries
// from sq_base, copies words from source to destination over a single
// request/ready memory port, writes a 16-byte completion record to cq_base,
// advances the shared ring index and pulses irq on request.
// Assumes: one outstanding read, read data returned with mem_rvalid in a later
// cycle, word-aligned bases and buffer addresses, and IDX_W <= 16.
module ring_copy_engine
    import ring_pkg::*;
#(
    parameter int unsigned ADDR_W = 64,
    parameter int unsigned IDX_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [ADDR_W-1:0] sq_base,
    input  logic [ADDR_W-1:0] cq_base,
    input  logic [IDX_W-1:0]  depth_m1,
    input  logic [IDX_W-1:0]  sq_tail,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic              mem_ready,
    input  logic              mem_rvalid,
    input  logic [31:0]       mem_rdata,
    output logic [IDX_W-1:0]  sq_head,
    output logic              irq
);

    localparam int unsigned CNT_W    = $clog2(SQE_WORDS);
    localparam int unsigned SQE_SH   = $clog2(SQE_WORDS * 4);
    localparam int unsigned CQE_SH   = $clog2(CQE_WORDS * 4);
    localparam int unsigned CQ_CNT_W = $clog2(CQE_WORDS);

    eng_state_e        state_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [31:0]       ent_q [SQE_WORDS];
    logic [31:0]       off_q;
    logic [31:0]       buf_q;
    logic [14:0]       st_q;
    logic              ien_q;
    logic              irq_q;

    logic [IDX_W-1:0]  idx_nxt;
    logic              adv;
    logic              accepted;
    logic              last_cq_word;

    logic              dec_copy;
    logic [14:0]       dec_status;
    logic              dec_irq;

    logic [ADDR_W-1:0] sqe_addr;
    logic [ADDR_W-1:0] cqe_addr;
    logic [ADDR_W-1:0] src_addr;
    logic [ADDR_W-1:0] dst_addr;
    logic [31:0]       cq_word;

    ring_index #(.IDX_W(IDX_W)) u_index (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (adv),
        .last  (depth_m1),
        .idx   (sq_head),
        .nxt   (idx_nxt)
    );

    sqe_decode u_decode (
        .opcode   (ent_q[0][3:0]),
        .irq_bit  (ent_q[0][8]),
        .byte_len (ent_q[3]),
        .do_copy  (dec_copy),
        .status   (dec_status),
        .want_irq (dec_irq)
    );

    // address generation for entry, record and payload words
    always_comb begin
        sqe_addr = sq_base + ADDR_W'({sq_head, {SQE_SH{1'b0}}});
        cqe_addr = cq_base + ADDR_W'({sq_head, {CQE_SH{1'b0}}});
        src_addr = ADDR_W'({ent_q[5], ent_q[4]}) + ADDR_W'(off_q);
        dst_addr = ADDR_W'({ent_q[7], ent_q[6]}) + ADDR_W'(off_q);
    end

    // completion record word selected by the record word counter
    always_comb begin
        case (cnt_q[CQ_CNT_W-1:0])
            2'd2:    cq_word = {16'h0000, 16'(idx_nxt)};
            2'd3:    cq_word = {st_q, 1'b1, 16'h0000};
            default: cq_word = 32'h0;
        endcase
    end

    // memory port driven from the current state
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = 32'h0;
        case (state_q)
            ST_FETCH_REQ: begin
                mem_req  = 1'b1;
                mem_addr = sqe_addr + ADDR_W'({cnt_q, 2'b00});
            end
            ST_RD_REQ: begin
                mem_req  = 1'b1;
                mem_addr = src_addr;
            end
            ST_WR_REQ: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = dst_addr;
                mem_wdata = buf_q;
            end
            ST_CPL_REQ: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = cqe_addr + ADDR_W'({cnt_q[CQ_CNT_W-1:0], 2'b00});
                mem_wdata = cq_word;
            end
            default: ;
        endcase
    end

    // handshake and end-of-entry detection
    always_comb begin
        accepted     = mem_req && mem_ready;
        last_cq_word = (state_q == ST_CPL_REQ) && mem_ready &&
                       (cnt_q[CQ_CNT_W-1:0] == CQ_CNT_W'(CQE_WORDS - 1));
        adv          = last_cq_word;
    end

    // control sequencer: fetch, decode, copy, complete
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            off_q   <= 32'h0;
            st_q    <= CST_OK;
            ien_q   <= 1'b0;
            irq_q   <= 1'b0;
        end else begin
            irq_q <= last_cq_word && ien_q;
            case (state_q)
                ST_IDLE: begin
                    if (enable && (sq_head != sq_tail)) begin
                        cnt_q   <= '0;
                        state_q <= ST_FETCH_REQ;
                    end
                end
                ST_FETCH_REQ: begin
                    if (accepted) state_q <= ST_FETCH_WAIT;
                end
                ST_FETCH_WAIT: begin
                    if (mem_rvalid) begin
                        if (cnt_q == CNT_W'(SQE_WORDS - 1)) begin
                            state_q <= ST_DECODE;
                        end else begin
                            cnt_q   <= cnt_q + 1'b1;
                            state_q <= ST_FETCH_REQ;
                        end
                    end
                end
                ST_DECODE: begin
                    st_q    <= dec_status;
                    ien_q   <= dec_irq;
                    off_q   <= 32'h0;
                    cnt_q   <= '0;
                    state_q <= dec_copy ? ST_RD_REQ : ST_CPL_REQ;
                end
                ST_RD_REQ: begin
                    if (accepted) state_q <= ST_RD_WAIT;
                end
                ST_RD_WAIT: begin
                    if (mem_rvalid) state_q <= ST_WR_REQ;
                end
                ST_WR_REQ: begin
                    if (accepted) begin
                        off_q   <= off_q + 32'd4;
                        state_q <= (off_q + 32'd4 == ent_q[3]) ? ST_CPL_REQ : ST_RD_REQ;
                    end
                end
                ST_CPL_REQ: begin
                    if (accepted) begin
                        if (last_cq_word) begin
                            state_q <= ST_IDLE;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // data capture: entry words during fetch, payload word during copy
    always_ff @(posedge clk) begin
        if (state_q == ST_FETCH_WAIT && mem_rvalid) begin
            ent_q[cnt_q] <= mem_rdata;
        end
        if (state_q == ST_RD_WAIT && mem_rvalid) begin
            buf_q <= mem_rdata;
        end
    end

    assign irq = irq_q;

    // a stalled request keeps its command and data
    assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) &&
                                     $stable(mem_we) && $stable(mem_wdata)));

    // interrupt is a single-cycle pulse
    assert_irq_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    // interrupt follows an accepted write by one cycle
    assert_irq_after_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(mem_req && mem_ready && mem_we));

    // head only moves after an accepted write
    assert_head_after_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sq_head != $past(sq_head)) |-> $past(mem_req && mem_ready && mem_we));

    // nothing is requested while disabled and idle at the previous edge
    assert_quiet_when_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q == ST_IDLE) && !$past(enable)) |-> !mem_req);

endmodule

// File: tb/ring_copy_engine_test.sv
module ring_copy_engine_test;

    localparam int DEPTH = 4;
    localparam logic [63:0] SQB   = 64'hA000_0000_0000_0100;
    localparam logic [63:0] CQB   = 64'h0000_0001_0000_0400;
    localparam logic [63:0] SRCB  = 64'h0000_0007_0000_1000;
    localparam logic [63:0] DSTB  = 64'h0000_0003_0000_2000;
    localparam int SRC_IDX = 32'h1000 / 4;
    localparam int DST_IDX = 32'h2000 / 4;
    localparam logic [31:0] SENT = 32'hDEAD_BEEF;
    localparam int LOGN = 8192;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic [9:0]  depth_m1 = 10'(DEPTH - 1);
    logic [9:0]  sq_tail = '0;
    logic        mem_req, mem_we, mem_ready, mem_rvalid, irq;
    logic [63:0] mem_addr;
    logic [31:0] mem_wdata, mem_rdata;
    logic [9:0]  sq_head;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    always #5 clk = ~clk;

    ring_copy_engine uut (
        .clk(clk), .rst_n(rst_n), .enable(enable),
        .sq_base(SQB), .cq_base(CQB), .depth_m1(depth_m1), .sq_tail(sq_tail),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata), .sq_head(sq_head), .irq(irq)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] pat(input int i);
        return 32'hC0DE_0000 ^ (i * 40503);
    endfunction

    // ---------------- memory model ----------------
    logic [31:0] mem [4096];
    logic        bd_we = 1'b0;
    int          bd_idx = 0;
    logic [31:0] bd_data = '0;
    int          rdy_mode = 0;
    logic [15:0] lfsr = 16'hACE1;

    always @(posedge clk) begin
        cyc  <= cyc + 1;
        lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        case (rdy_mode)
            1:       mem_ready <= cyc[0];
            2:       mem_ready <= lfsr[3];
            3:       mem_ready <= (cyc % 3 == 0);
            default: mem_ready <= 1'b1;
        endcase
        if (bd_we) mem[bd_idx[11:0]] <= bd_data;
        if (mem_req && mem_ready && mem_we) mem[mem_addr[13:2]] <= mem_wdata;
        mem_rvalid <= mem_req && mem_ready && !mem_we;
        if (mem_req && mem_ready && !mem_we) mem_rdata <= mem[mem_addr[13:2]];
    end

    task automatic bd_write(input int idx, input logic [31:0] d);
        bd_idx = idx; bd_data = d; bd_we = 1'b1;
        @(negedge clk);
        bd_we = 1'b0;
    endtask

    // ---------------- monitor ----------------
    logic [63:0] lg_addr [LOGN];
    logic        lg_we   [LOGN];
    logic [31:0] lg_data [LOGN];
    int          log_n = 0;
    int          irq_cnt = 0;
    logic        p_stall = 1'b0, p_we = 1'b0, p_cqlast = 1'b0, p_irq = 1'b0;
    logic [63:0] p_addr = '0;
    logic [31:0] p_data = '0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (p_stall) begin
                chk(mem_req && mem_we == p_we && mem_addr == p_addr && mem_wdata == p_data,
                    "R11 stalled request changed", mem_addr, p_addr);
            end
            if (irq) begin
                irq_cnt++;
                chk(p_cqlast, "R10 irq not right after last record write", 64'(p_cqlast), 64'd1);
                chk(!p_irq, "R10 irq longer than one cycle", 64'(p_irq), 64'd0);
            end
            if (mem_req && mem_ready && log_n < LOGN) begin
                lg_addr[log_n] = mem_addr;
                lg_we[log_n]   = mem_we;
                lg_data[log_n] = mem_wdata;
                log_n++;
            end
            p_stall  = mem_req && !mem_ready;
            p_we     = mem_we;
            p_addr   = mem_addr;
            p_data   = mem_wdata;
            p_cqlast = mem_req && mem_ready && mem_we && mem_addr[63:32] == CQB[63:32] &&
                       mem_addr[3:0] == 4'hC;
            p_irq    = irq;
        end else begin
            p_stall = 1'b0; p_cqlast = 1'b0; p_irq = 1'b0;
        end
    end

    // ---------------- global watchdog ----------------
    always @(negedge clk) begin
        if (cyc > 150000) begin
            chk(1'b0, "watchdog expired", 64'(cyc), 64'd150000);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    // ---------------- batch bookkeeping ----------------
    int          sw_tail = 0;
    int          lp = 0;
    int          ex_slot [4];
    logic [3:0]  ex_op   [4];
    logic        ex_ien  [4];
    int          ex_len  [4];
    int          ex_soff [4];
    logic [14:0] ex_st   [4];

    task automatic put_entry(input int k, input logic [3:0] op, input logic ien,
                             input logic [2:0] attr, input int len, input int soff);
        int slot;
        int base;
        slot = (sw_tail + k) % DEPTH;
        base = (int'(SQB[13:0]) + slot * 32) / 4;
        ex_slot[k] = slot; ex_op[k] = op; ex_ien[k] = ien; ex_len[k] = len; ex_soff[k] = soff;
        ex_st[k] = (op != 4'h4) ? 15'd1 : (len == 0) ? 15'd2 : (len % 4 != 0) ? 15'd3 : 15'd0;
        bd_write(base + 0, (32'(attr) << 12) | (32'(ien) << 8) | 32'(op));
        bd_write(base + 1, 32'h1234_5678);
        bd_write(base + 2, 32'(attr) << 24);
        bd_write(base + 3, 32'(len));
        bd_write(base + 4, SRCB[31:0] + 32'(soff));
        bd_write(base + 5, SRCB[63:32]);
        bd_write(base + 6, DSTB[31:0] + 32'(k * 256));
        bd_write(base + 7, DSTB[63:32]);
        for (int w = 0; w < 17; w++) bd_write(DST_IDX + k * 64 + w, SENT);
    endtask

    task automatic run_batch(input int n);
        int irq0;
        int t;
        irq0 = irq_cnt;
        sw_tail = (sw_tail + n) % DEPTH;
        sq_tail = 10'(sw_tail);
        t = 0;
        while (sq_head != 10'(sw_tail) && t < 20000) begin
            @(negedge clk);
            t++;
        end
        chk(t < 20000, "R9 head never reached tail", 64'(sq_head), 64'(sw_tail));
        repeat (3) @(negedge clk);
        chk(sq_head == 10'(sw_tail), "R9 head after batch", 64'(sq_head), 64'(sw_tail));
        for (int k = 0; k < n; k++) check_entry(k);
        chk(log_n == lp, "R5 extra memory accesses after batch", 64'(log_n), 64'(lp));
        lp = log_n;
        begin
            int want;
            want = 0;
            for (int k = 0; k < n; k++) want += int'(ex_ien[k]);
            chk(irq_cnt - irq0 == want, "R10 irq count", 64'(irq_cnt - irq0), 64'(want));
        end
    endtask

    task automatic check_entry(input int k);
        logic [63:0] a;
        logic [31:0] d;
        int slot;
        bit cp;
        string stag;
        slot = ex_slot[k];
        cp = (ex_st[k] == 15'd0);
        for (int i = 0; i < 8; i++) begin
            a = SQB + 64'(slot * 32 + i * 4);
            chk(!lg_we[lp] && lg_addr[lp] == a, "R3 entry fetch order/address", lg_addr[lp], a);
            lp++;
        end
        if (cp) begin
            for (int w = 0; w < ex_len[k] / 4; w++) begin
                a = SRCB + 64'(ex_soff[k] + w * 4);
                chk(!lg_we[lp] && lg_addr[lp] == a, "R4 source read", lg_addr[lp], a);
                lp++;
                a = DSTB + 64'(k * 256 + w * 4);
                d = pat(SRC_IDX + ex_soff[k] / 4 + w);
                chk(lg_we[lp] && lg_addr[lp] == a && lg_data[lp] == d,
                    "R4 destination write", {lg_addr[lp][31:0], lg_data[lp]}, {a[31:0], d});
                lp++;
                chk(mem[DST_IDX + k * 64 + w] == d, "R4 destination data",
                    64'(mem[DST_IDX + k * 64 + w]), 64'(d));
            end
            chk(mem[DST_IDX + k * 64 + ex_len[k] / 4] == SENT, "R4 word after buffer touched",
                64'(mem[DST_IDX + k * 64 + ex_len[k] / 4]), 64'(SENT));
        end else begin
            chk(mem[DST_IDX + k * 64] == SENT, "R5 destination touched on error",
                64'(mem[DST_IDX + k * 64]), 64'(SENT));
        end
        case (ex_st[k])
            15'd1:   stag = "R5 status for bad opcode";
            15'd2:   stag = "R6 status for zero length";
            15'd3:   stag = "R7 status for unaligned length";
            default: stag = "R8 success status";
        endcase
        for (int i = 0; i < 4; i++) begin
            a = CQB + 64'(slot * 16 + i * 4);
            case (i)
                2:       d = 32'((slot + 1) % DEPTH);
                3:       d = {ex_st[k], 1'b1, 16'h0};
                default: d = 32'h0;
            endcase
            chk(lg_we[lp] && lg_addr[lp] == a, "R8 record write address", lg_addr[lp], a);
            if (i == 3) chk(lg_data[lp] == d, stag, 64'(lg_data[lp]), 64'(d));
            else chk(lg_data[lp] == d, "R8 record word value", 64'(lg_data[lp]), 64'(d));
            lp++;
        end
    endtask

    // ---------------- stimulus ----------------
    initial begin
        repeat (4) @(negedge clk);
        chk(sq_head == '0, "R1 head in reset", 64'(sq_head), 64'd0);
        chk(!irq, "R1 irq in reset", 64'(irq), 64'd0);
        chk(!mem_req, "R1 req in reset", 64'(mem_req), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(sq_head == '0 && !irq && !mem_req, "R1 state after reset",
            {mem_req, irq, 52'd0, sq_head}, 64'd0);
        for (int i = 0; i < 64; i++) bd_write(SRC_IDX + i, pat(SRC_IDX + i));

        // R2: posted work with enable low, then enabled with an empty ring
        put_entry(0, 4'h4, 1'b1, 3'd0, 8, 0);
        sq_tail = 10'd1;
        repeat (20) @(negedge clk);
        chk(log_n == 0, "R2 access while disabled", 64'(log_n), 64'd0);
        chk(sq_head == '0, "R2 head moved while disabled", 64'(sq_head), 64'd0);
        sq_tail = 10'd0;
        enable = 1'b1;
        repeat (20) @(negedge clk);
        chk(log_n == 0, "R2 access with empty ring", 64'(log_n), 64'd0);

        // two copies in one batch
        put_entry(0, 4'h4, 1'b1, 3'd5, 16, 8);
        put_entry(1, 4'h4, 1'b0, 3'd2, 4, 0);
        run_batch(2);

        // error entries across the ring end
        put_entry(0, 4'h1, 1'b0, 3'd0, 8, 0);
        put_entry(1, 4'h4, 1'b1, 3'd0, 0, 0);
        put_entry(2, 4'h4, 1'b0, 3'd0, 6, 0);
        run_batch(3);
        put_entry(0, 4'hF, 1'b1, 3'd7, 0, 0);
        run_batch(1);

        // sweep lengths under each ready pattern
        for (int m = 0; m < 4; m++) begin
            rdy_mode = m;
            for (int len = 4; len <= 48; len += 4) begin
                put_entry(0, 4'h4, 1'((len / 4) % 2), 3'(m), len, (len % 16));
                run_batch(1);
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule